// File: doc/BRIEF.md
# Fused Multiply-Subtract Special-Operand Resolver

This block sits in front of a single-precision fused multiply-subtract unit that forms `acc - (a * b)`. It is purely combinational. Each of the three 32-bit operands is sorted into one of six classes: zero, denormal, normal, infinity, quiet NaN or signalling NaN. A fixed priority over those classes then decides whether the answer is already known.

When the answer is known, the block raises a bypass flag and presents the finished 32-bit result. It also raises an invalid-operation flag where one is due. When the answer is not known, the arithmetic datapath must compute it. In that case the block holds the bypass flag low and marks which operands are denormal and so need pre-normalization before the multiply and add.

Top module: `fms_special_resolve`

## Requirements
- R1: A value whose exponent field is all ones and whose fraction is nonzero is a NaN. It is quiet when fraction bit 22 is 1 and signalling when that bit is 0. A value with a zero exponent and a nonzero fraction is denormal, whatever its fraction bit 22 holds.
- R2: A signalling-NaN accumulator wins over every other operand combination. It sets bypass and invalid, and the result is the accumulator quieted.
- R3: If the accumulator is not a signalling NaN, a signalling NaN in `mul_a_i` is returned quieted, with invalid set, whatever `mul_b_i` holds. Otherwise a signalling NaN in `mul_b_i` is returned quieted, with invalid set.
- R4: With no signalling NaN present, a quiet-NaN `mul_a_i` is returned unchanged. Otherwise a quiet-NaN `mul_b_i` is returned unchanged. Invalid stays clear in both cases.
- R5: Infinity times zero, in either order, returns the accumulator if it is a quiet NaN, with invalid clear. Otherwise it sets invalid and returns the default NaN 0x7FBFFFFF.
- R6: Infinity times a nonzero non-NaN value returns a quiet-NaN accumulator unchanged. Otherwise it returns infinity whose sign is the XOR of the two multiplicand signs.
- R7: A zero product of non-NaN, non-infinite multiplicands returns infinity with the accumulator's sign if the accumulator is infinite. Otherwise it returns the accumulator bit for bit.
- R8: A finite nonzero product returns a quiet-NaN accumulator unchanged. An infinite accumulator gives infinity with the accumulator's sign.
- R9: All other cases clear bypass and invalid and drive the result to zero. In that case `dnorm_o` bit 0 (accumulator), bit 1 (`mul_a_i`) and bit 2 (`mul_b_i`) flag the denormal operands. `dnorm_o` is zero whenever bypass is set.
- R10: Quieting sets fraction bit 22 and keeps the sign bit and every other payload bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 32 | Accumulator operand (minuend) |
| mul_a_i | input | 32 | First multiplicand |
| mul_b_i | input | 32 | Second multiplicand |
| bypass_o | output | 1 | Result is final; the datapath is skipped |
| result_o | output | 32 | Special result when bypass is set, zero otherwise |
| invalid_o | output | 1 | Invalid-operation exception |
| dnorm_o | output | 3 | Denormal operands that need pre-normalization (datapath case only) |

## Verification
The block holds no state, so a wrong priority or class decision shows at the ports at once, in the same evaluation as the operands that provoke it. A misordered NaN check returns the wrong operand's payload. A misdecoded class either sends a special case to the datapath, where bypass is low and the result is zero, or bypasses a finite case. A lost quieting bit leaves bit 22 clear in the returned NaN. Sweeping every class triple with distinct per-operand payloads and signs makes each of these faults visible as a bit difference in the result or the flags.

// File: rtl/fms_sc_pkg.sv
`timescale 1ns/1ps
package fms_sc_pkg;
  typedef enum logic [2:0] {
    CL_ZERO  = 3'd0,
    CL_DNORM = 3'd1,
    CL_NORM  = 3'd2,
    CL_INF   = 3'd3,
    CL_QNAN  = 3'd4,
    CL_SNAN  = 3'd5
  } op_class_e;

  localparam int unsigned OP_ACC = 0;
  localparam int unsigned OP_A   = 1;
  localparam int unsigned OP_B   = 2;
  localparam int unsigned N_OPS  = 3;
endpackage

// File: rtl/fsc_classify.sv
`timescale 1ns/1ps
module fsc_classify
  import fms_sc_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_i,
  output op_class_e    class_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = op_i[W-2 -: EXP_W];
  assign frac_f = op_i[FRAC_W-1:0];

  always_comb begin
    if (exp_f == '0)
      class_o = (frac_f == '0) ? CL_ZERO : CL_DNORM;
    else if (exp_f == '1) begin
      if (frac_f == '0)          class_o = CL_INF;
      else if (frac_f[FRAC_W-1]) class_o = CL_QNAN;
      else                       class_o = CL_SNAN;
    end else
      class_o = CL_NORM;
  end
endmodule

// File: rtl/fsc_quiet.sv
`timescale 1ns/1ps
module fsc_quiet #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_i,
  output logic [W-1:0] quiet_o
);
  localparam logic [W-1:0] QBIT = W'(1) << (FRAC_W - 1);

  assign quiet_o = op_i | QBIT;
endmodule

// File: rtl/fsc_resolver.sv
`timescale 1ns/1ps
module fsc_resolver
  import fms_sc_pkg::*;
#(
  parameter int unsigned EXP_W       = 8,
  parameter int unsigned FRAC_W      = 23,
  localparam int unsigned W          = 1 + EXP_W + FRAC_W,
  parameter logic [W-1:0] DEFAULT_NAN = 32'h7FBF_FFFF
) (
  input  op_class_e          cls_i   [N_OPS],
  input  logic [W-1:0]       op_i    [N_OPS],
  input  logic [W-1:0]       quiet_i [N_OPS],
  output logic               bypass_o,
  output logic [W-1:0]       result_o,
  output logic               invalid_o,
  output logic [N_OPS-1:0]   dnorm_o
);
  function automatic logic [W-1:0] inf_of(input logic sgn);
    return {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  op_class_e c_acc, c_a, c_b;
  logic      s_acc, s_a, s_b;
  logic      inf_zero, any_inf, any_zero;

  assign c_acc = cls_i[OP_ACC];
  assign c_a   = cls_i[OP_A];
  assign c_b   = cls_i[OP_B];
  assign s_acc = op_i[OP_ACC][W-1];
  assign s_a   = op_i[OP_A][W-1];
  assign s_b   = op_i[OP_B][W-1];

  assign inf_zero = (c_a == CL_INF && c_b == CL_ZERO) || (c_a == CL_ZERO && c_b == CL_INF);
  assign any_inf  = (c_a == CL_INF) || (c_b == CL_INF);
  assign any_zero = (c_a == CL_ZERO) || (c_b == CL_ZERO);

  // fixed priority: acc sNaN, a sNaN, b sNaN, a qNaN, b qNaN, inf*0, inf, zero product, finite
  always_comb begin
    bypass_o  = 1'b1;
    invalid_o = 1'b0;
    result_o  = '0;
    if (c_acc == CL_SNAN) begin
      result_o  = quiet_i[OP_ACC];
      invalid_o = 1'b1;
    end else if (c_a == CL_SNAN) begin
      result_o  = quiet_i[OP_A];
      invalid_o = 1'b1;
    end else if (c_b == CL_SNAN) begin
      result_o  = quiet_i[OP_B];
      invalid_o = 1'b1;
    end else if (c_a == CL_QNAN) begin
      result_o = op_i[OP_A];
    end else if (c_b == CL_QNAN) begin
      result_o = op_i[OP_B];
    end else if (inf_zero) begin
      if (c_acc == CL_QNAN) result_o = op_i[OP_ACC];
      else begin
        result_o  = DEFAULT_NAN;
        invalid_o = 1'b1;
      end
    end else if (any_inf) begin
      result_o = (c_acc == CL_QNAN) ? op_i[OP_ACC] : inf_of(s_a ^ s_b);
    end else if (any_zero) begin
      result_o = (c_acc == CL_INF) ? inf_of(s_acc) : op_i[OP_ACC];
    end else if (c_acc == CL_QNAN) begin
      result_o = op_i[OP_ACC];
    end else if (c_acc == CL_INF) begin
      result_o = inf_of(s_acc);
    end else begin
      bypass_o = 1'b0;
    end
  end

  for (genvar g = 0; g < N_OPS; g++) begin : g_dnorm
    assign dnorm_o[g] = !bypass_o && (cls_i[g] == CL_DNORM);
  end

  always_comb begin
    p_acc_snan_wins_r2: assert (c_acc != CL_SNAN || (bypass_o && invalid_o));
    p_invalid_implies_bypass_r5: assert (!invalid_o || bypass_o);
    p_dnorm_only_datapath_r9: assert (!bypass_o || dnorm_o == '0);
    p_datapath_zero_result_r9: assert (bypass_o || result_o == '0);
    p_datapath_operands_finite_r8: assert (bypass_o ||
      (c_a inside {CL_NORM, CL_DNORM} && c_b inside {CL_NORM, CL_DNORM} &&
       c_acc inside {CL_ZERO, CL_NORM, CL_DNORM}));
    p_qnan_mul_no_invalid_r4: assert (!(c_acc != CL_SNAN && c_a == CL_QNAN && c_b != CL_SNAN) ||
      (!invalid_o && result_o == op_i[OP_A]));
  end
endmodule

// File: rtl/fms_special_resolve.sv
`timescale 1ns/1ps
module fms_special_resolve
  import fms_sc_pkg::*;
#(
  parameter int unsigned EXP_W        = 8,
  parameter int unsigned FRAC_W       = 23,
  localparam int unsigned W           = 1 + EXP_W + FRAC_W,
  parameter logic [W-1:0] DEFAULT_NAN = 32'h7FBF_FFFF
) (
  input  logic [W-1:0]     acc_i,
  input  logic [W-1:0]     mul_a_i,
  input  logic [W-1:0]     mul_b_i,
  output logic             bypass_o,
  output logic [W-1:0]     result_o,
  output logic             invalid_o,
  output logic [N_OPS-1:0] dnorm_o
);
  logic [W-1:0] ops   [N_OPS];
  logic [W-1:0] quiet [N_OPS];
  op_class_e    cls   [N_OPS];

  assign ops[OP_ACC] = acc_i;
  assign ops[OP_A]   = mul_a_i;
  assign ops[OP_B]   = mul_b_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    fsc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls (
      .op_i   (ops[g]),
      .class_o(cls[g])
    );
    fsc_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_quiet (
      .op_i   (ops[g]),
      .quiet_o(quiet[g])
    );
  end

  fsc_resolver #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .DEFAULT_NAN(DEFAULT_NAN)) i_res (
    .cls_i    (cls),
    .op_i     (ops),
    .quiet_i  (quiet),
    .bypass_o (bypass_o),
    .result_o (result_o),
    .invalid_o(invalid_o),
    .dnorm_o  (dnorm_o)
  );

  always_comb begin
    p_nan_result_quiet_bit_r10: assert (!(bypass_o && invalid_o && result_o != DEFAULT_NAN) ||
                                        result_o[FRAC_W-1]);
  end
endmodule

// File: tb/test_fms_special_resolve.sv
`timescale 1ns/1ps
module test_fms_special_resolve;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] acc, ma, mb, res;
  logic        byp, inv;
  logic [2:0]  dn;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  fms_special_resolve i_fms_special_resolve (
    .acc_i(acc), .mul_a_i(ma), .mul_b_i(mb),
    .bypass_o(byp), .result_o(res), .invalid_o(inv), .dnorm_o(dn)
  );

  typedef struct packed {
    logic [31:0] acc, a, b, res;
    logic        byp, inv;
    logic [2:0]  dn;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0, 3'b000, 8'd7},
    '{32'hFF80_1234, 32'h7FC0_0005, 32'h7F80_0006, 32'hFFC0_1234, 1'b1, 1'b1, 3'b000, 8'd2},
    '{32'h7FC0_0001, 32'h7F80_0055, 32'hFF80_0066, 32'h7FC0_0055, 1'b1, 1'b1, 3'b000, 8'd3},
    '{32'h3F80_0000, 32'hFFC0_0009, 32'h7F80_000A, 32'h7FC0_000A, 1'b1, 1'b1, 3'b000, 8'd3},
    '{32'h3F80_0000, 32'h7FC0_0003, 32'h7FC0_0004, 32'h7FC0_0003, 1'b1, 1'b0, 3'b000, 8'd4},
    '{32'h3F80_0000, 32'h7F80_0000, 32'h8000_0000, 32'h7FBF_FFFF, 1'b1, 1'b1, 3'b000, 8'd5},
    '{32'h7FC0_0077, 32'h8000_0000, 32'h7F80_0000, 32'h7FC0_0077, 1'b1, 1'b0, 3'b000, 8'd5},
    '{32'h3F80_0000, 32'hFF80_0000, 32'h4000_0000, 32'hFF80_0000, 1'b1, 1'b0, 3'b000, 8'd6},
    '{32'hFF80_0000, 32'h0000_0000, 32'h0000_0001, 32'hFF80_0000, 1'b1, 1'b0, 3'b000, 8'd7},
    '{32'h8000_0002, 32'h3F80_0000, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b0, 3'b101, 8'd9},
    '{32'h7F80_0000, 32'h3F80_0000, 32'hC000_0000, 32'h7F80_0000, 1'b1, 1'b0, 3'b000, 8'd8},
    '{32'hFFC0_0042, 32'h0000_0010, 32'h3F80_0000, 32'hFFC0_0042, 1'b1, 1'b0, 3'b000, 8'd8},
    '{32'h0000_0000, 32'h0040_0000, 32'h8000_0003, 32'h0000_0000, 1'b0, 1'b0, 3'b110, 8'd1},
    '{32'h7F80_0001, 32'h3F80_0000, 32'h3F80_0000, 32'h7FC0_0001, 1'b1, 1'b1, 3'b000, 8'd10}
  };

  // class codes for the sweep: 0 zero, 1 denormal, 2 normal, 3 inf, 4 qNaN, 5 sNaN
  function automatic logic [31:0] rep(input int c, input int op, input logic sgn);
    logic [31:0] v;
    case (c)
      0: v = 32'h0000_0000;
      1: v = 32'h0000_0123;
      2: v = 32'h3FC0_0000;
      3: v = 32'h7F80_0000;
      4: v = 32'h7FC0_0000 | (32'h10 + 32'(op));
      default: v = 32'h7F80_0000 | (32'h10 + 32'(op));
    endcase
    v[31] = sgn;
    return v;
  endfunction

  task automatic model(input int cc, input int ca, input int cb,
                       input logic [31:0] vc, input logic [31:0] va, input logic [31:0] vb,
                       output logic [31:0] er, output logic eb, output logic ei,
                       output logic [2:0] ed, output int rq);
    eb = 1'b1; ei = 1'b0; er = 32'h0; ed = 3'b000; rq = 9;
    if (cc == 5)              begin er = vc | 32'h0040_0000; ei = 1'b1; rq = 2; end
    else if (ca == 5)         begin er = va | 32'h0040_0000; ei = 1'b1; rq = 3; end
    else if (cb == 5)         begin er = vb | 32'h0040_0000; ei = 1'b1; rq = 3; end
    else if (ca == 4)         begin er = va; rq = 4; end
    else if (cb == 4)         begin er = vb; rq = 4; end
    else if ((ca == 3 && cb == 0) || (ca == 0 && cb == 3)) begin
      rq = 5;
      if (cc == 4) er = vc; else begin er = 32'h7FBF_FFFF; ei = 1'b1; end
    end else if (ca == 3 || cb == 3) begin
      rq = 6;
      er = (cc == 4) ? vc : {va[31] ^ vb[31], 31'h7F80_0000};
    end else if (ca == 0 || cb == 0) begin
      rq = 7;
      er = (cc == 3) ? {vc[31], 31'h7F80_0000} : vc;
    end else if (cc == 4) begin er = vc; rq = 8; end
    else if (cc == 3) begin er = {vc[31], 31'h7F80_0000}; rq = 8; end
    else begin
      eb = 1'b0;
      ed = {cb == 1, ca == 1, cc == 1};
    end
  endtask

  task automatic compare(input int rq, input logic [31:0] er, input logic eb,
                         input logic ei, input logic [2:0] ed);
    n_chk++;
    if (res !== er || byp !== eb || inv !== ei || dn !== ed) begin
      n_bad++;
      $display("FAIL R%0d acc=%h a=%h b=%h: got res=%h byp=%b inv=%b dn=%b exp res=%h byp=%b inv=%b dn=%b",
               rq, acc, ma, mb, res, byp, inv, dn, er, eb, ei, ed);
    end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] er;
    logic eb, ei;
    logic [2:0] ed;
    int rq;
    acc = '0; ma = '0; mb = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // reset state: all-zero operands give zero product, acc passed through (R7)
    #1 compare(7, 32'h0, 1'b1, 1'b0, 3'b000);

    // directed vectors: R1..R10
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      acc = VEC[i].acc; ma = VEC[i].a; mb = VEC[i].b;
      #1 compare(int'(VEC[i].req), VEC[i].res, VEC[i].byp, VEC[i].inv, VEC[i].dn);
    end

    // full class sweep with rotating signs: R2 R3 R4 R5 R6 R7 R8 R9
    for (int k = 0; k < 216; k++) begin
      int cc, ca, cb;
      cc = k % 6; ca = (k / 6) % 6; cb = k / 36;
      @(negedge clk);
      acc = rep(cc, 0, k[0]);
      ma  = rep(ca, 1, k[1]);
      mb  = rep(cb, 2, k[2] ^ k[0]);
      model(cc, ca, cb, acc, ma, mb, er, eb, ei, ed, rq);
      #1 compare(rq, er, eb, ei, ed);
    end

    // R10: negative sNaN with wide payload keeps sign and payload
    @(negedge clk);
    acc = 32'h3F80_0000; ma = 32'hFFAA_AAAA; mb = 32'h3F80_0000;
    #1 compare(10, 32'hFFEA_AAAA, 1'b1, 1'b1, 3'b000);

    // R1: denormal with fraction MSB set in acc, finite product -> datapath
    @(negedge clk);
    acc = 32'h807F_FFFF; ma = 32'h3F80_0000; mb = 32'h4000_0000;
    #1 compare(1, 32'h0, 1'b0, 1'b0, 3'b001);

    // R6: inf times inf with opposite signs
    @(negedge clk);
    acc = 32'h0000_0000; ma = 32'h7F80_0000; mb = 32'hFF80_0000;
    #1 compare(6, 32'hFF80_0000, 1'b1, 1'b0, 3'b000);

    done = 1'b1;
    finish_run();
  end
endmodule